// File: doc/BRIEF.md
# Non-Retriggerable Digital One-Shot Timer

This block is a clocked monostable pulse generator. It watches three asynchronous control levels: an active-low start input, an active-high start input and an active-low clear. When a qualifying transition is seen, it drives one output pulse whose length in clock cycles is the value on the duration input at the moment the trigger is accepted. A complementary output always mirrors the true output inverted.

All three control inputs pass through a two-flop synchronizer before edge detection, so every response has a fixed latency from the raw input change. While a pulse is running, the block ignores trigger activity. Taking clear low stops a running pulse and blocks new triggers for as long as clear stays low. The block has no data stream, so all pins are plain control and status levels with no handshake.

Top module: `oneshot_pulse`

## Requirements
- R1: With `trig_n_i` held low, a low-to-high change on `trig_i` starts a pulse.
- R2: With `trig_i` held high, a high-to-low change on `trig_n_i` starts a pulse.
- R3: With `trig_n_i` low and `trig_i` high, a low-to-high change on `clr_n_i` starts a pulse.
- R4: Edges on one trigger input start nothing while the other input is inactive, that is `trig_n_i` high or `trig_i` low.
- R5: While a pulse is running, trigger transitions are ignored. The pulse is not restarted or lengthened, and events during it start no later pulse.
- R6: When `clr_n_i` goes low, `pulse_o` falls 2 cycles after the raw change. No trigger event is accepted while clear is low.
- R7: The pulse length does not depend on how long a trigger is held. `dur_i` is captured only in the cycle the trigger is accepted, and later changes do not alter a running pulse.
- R8: During and after reset `pulse_o` is low and `pulse_n_o` is high. Input levels that already form a trigger condition when reset is released produce no pulse.
- R9: A pulse lasts exactly N cycles, where N is the unsigned `dur_i` value captured. N = 0 produces no pulse.
- R10: `pulse_o` rises 3 clock edges after the raw input change that qualified the trigger.
- R11: `pulse_n_o` is always the inverse of `pulse_o`.
- R12: A new qualifying event is accepted as soon as the previous pulse has ended, including in the cycle right after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_n_i | input | 1 | Active-low trigger, acts on its falling edge, asynchronous |
| trig_i | input | 1 | Active-high trigger, acts on its rising edge, asynchronous |
| clr_n_i | input | 1 | Active-low clear, asynchronous; its release can also trigger |
| dur_i | input | DUR_W | Pulse length in clock cycles, sampled when a trigger is accepted |
| pulse_o | output | 1 | True output, high for the pulse |
| pulse_n_o | output | 1 | Complementary output |

## Verification
The bench changes inputs just after a falling clock edge and counts rising edges. A qualifying change made at count c is expected to show `pulse_o` high at the falling edge with count c+3. The pulse should then stay high for N samples. A clear driven at count d should show the output low at count d+2. The driver queues each expected start cycle and length, and the monitor samples only at falling edges and compares each finished pulse with the head of the queue. For the cases where no pulse should occur, the bench compares the count of pulse starts before and after the stimulus, once the 3-cycle latency has passed.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef struct packed {
    logic trig_n;
    logic trig;
    logic clr_n;
  } os_lvl_t;

  localparam os_lvl_t OS_IDLE = '{trig_n: 1'b1, trig: 1'b0, clr_n: 1'b1};
endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/oneshot_qual.sv
module oneshot_qual
  import oneshot_pkg::*;
#(
  parameter int ARM_LEN = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  os_lvl_t lvl,
  input  logic    busy,
  output logic    fire
);
  os_lvl_t            prev;
  logic [ARM_LEN-1:0] arm;
  logic               fall_a, rise_b, rise_c, cond;

  // Edges are not accepted until the synchronizer and the previous-level
  // register hold real input values, so levels present at reset start nothing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= OS_IDLE;
      arm  <= '0;
    end else begin
      prev <= lvl;
      arm  <= {arm[ARM_LEN-2:0], 1'b1};
    end
  end

  always_comb begin
    fall_a = prev.trig_n & ~lvl.trig_n;
    rise_b = ~prev.trig & lvl.trig;
    rise_c = ~prev.clr_n & lvl.clr_n;
    cond   = (fall_a & lvl.trig)
           | (rise_b & ~lvl.trig_n)
           | (rise_c & ~lvl.trig_n & lvl.trig);
    fire   = arm[ARM_LEN-1] & lvl.clr_n & ~busy & cond;
  end
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_n,
  input  logic             load,
  input  logic [DUR_W-1:0] dur,
  output logic [DUR_W-1:0] cnt,
  output logic             busy
);
  localparam logic [DUR_W-1:0] ONE = {{(DUR_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!clear_n) cnt <= '0;
    else if (load)     cnt <= dur;
    else if (busy)     cnt <= cnt - ONE;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/oneshot_pulse.sv
module oneshot_pulse
  import oneshot_pkg::*;
#(
  parameter int DUR_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_n_i,
  input  logic             trig_i,
  input  logic             clr_n_i,
  input  logic [DUR_W-1:0] dur_i,
  output logic             pulse_o,
  output logic             pulse_n_o
);
  localparam int LVL_W   = $bits(os_lvl_t);
  localparam int ARM_LEN = SYNC_STAGES + 1;

  os_lvl_t          lvl_raw, lvl_s;
  logic [DUR_W-1:0] cnt;
  logic             busy, fire, clr_s;

  assign lvl_raw = '{trig_n: trig_n_i, trig: trig_i, clr_n: clr_n_i};

  oneshot_sync #(
    .W      (LVL_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(OS_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (lvl_raw),
    .q    (lvl_s)
  );

  assign clr_s = lvl_s.clr_n;

  oneshot_qual #(.ARM_LEN(ARM_LEN)) u_qual (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (lvl_s),
    .busy (busy),
    .fire (fire)
  );

  oneshot_timer #(.DUR_W(DUR_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear_n(clr_s),
    .load   (fire),
    .dur    (dur_i),
    .cnt    (cnt),
    .busy   (busy)
  );

  // Synchronized clear masks the output at once; the counter empties next edge.
  assign pulse_o   = busy & clr_s;
  assign pulse_n_o = ~pulse_o;
endmodule

// File: rtl/oneshot_pulse_chk.sv
module oneshot_pulse_chk #(
  parameter int DUR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_s,
  input logic             fire,
  input logic [DUR_W-1:0] dur_i,
  input logic [DUR_W-1:0] cnt,
  input logic             pulse_o,
  input logic             pulse_n_o
);
  localparam logic [DUR_W-1:0] ONE = {{(DUR_W-1){1'b0}}, 1'b1};

  // R6: a low synchronized clear empties the timer on the next edge
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_s |=> (cnt == '0));

  // R7: the duration seen at acceptance is the one that is loaded
  a_r7_dur_captured: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt == $past(dur_i)));

  // R5: a running count only steps down or is cleared, never reloaded
  a_r5_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> ((cnt == $past(cnt) - ONE) || (cnt == '0)));

  // R10: the output only starts from an accepted trigger
  a_r10_start_from_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(fire));

  // R8: reset leaves the outputs idle
  a_r8_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!pulse_o && pulse_n_o));
endmodule

bind oneshot_pulse oneshot_pulse_chk #(.DUR_W(DUR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr_s    (clr_s),
  .fire     (fire),
  .dur_i    (dur_i),
  .cnt      (cnt),
  .pulse_o  (pulse_o),
  .pulse_n_o(pulse_n_o)
);

// File: tb/sim_oneshot_pulse.sv
module sim_oneshot_pulse;
  localparam int DUR_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tn = 1'b0, tr = 1'b1, cn = 1'b1;
  logic [DUR_W-1:0] dur = 16'd5;
  logic             pulse_o, pulse_n_o;

  typedef struct {
    int    rise;
    int    len;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0, fails = 0;
  int   rises = 0, rise_cyc = 0, compl_bad = 0;
  logic prev_p = 1'b0;
  bit   done = 1'b0;

  oneshot_pulse #(.DUR_W(DUR_W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_n_i(tn), .trig_i(tr), .clr_n_i(cn),
    .dur_i(dur), .pulse_o(pulse_o), .pulse_n_o(pulse_n_o)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(int rise, int len, string tag);
    exp_t e;
    e.rise = rise; e.len = len; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Monitor: measure each pulse and compare it with the queued expectation
  always @(negedge clk) begin
    if (rst_n) begin
      if (pulse_n_o !== ~pulse_o) compl_bad++;
      if (pulse_o && !prev_p) begin
        rise_cyc = cyc;
        rises++;
      end
      if (!pulse_o && prev_p) begin
        if (q.size() == 0) begin
          check(1'b0, "R5 unexpected pulse start", rise_cyc, -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(rise_cyc == e.rise, {e.tag, " start cycle"}, rise_cyc, e.rise);
          checks--;
          check(cyc - rise_cyc == e.len, {e.tag, " length"}, cyc - rise_cyc, e.len);
        end
      end
      prev_p = pulse_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog R1..", cyc, 0);
      summary();
    end
  end

  initial begin
    int c, r0;
    // R8: firing levels held through reset
    idle(3);
    check(pulse_o == 1'b0 && pulse_n_o == 1'b1, "R8 reset state", pulse_o, 0);
    rst_n = 1'b1;
    idle(12);
    check(rises == 0, "R8 no pulse after reset", rises, 0);
    tn = 1'b1; tr = 1'b0;
    idle(5);

    // R1 + R10: trig rises while trig_n low
    tn = 1'b0; idle(4);
    c = cyc; tr = 1'b1; push(c + 3, 5, "R1/R10");
    idle(12); tr = 1'b0; idle(3);

    // R2: trig_n falls while trig high (trig rise with trig_n high first: inhibited)
    tn = 1'b1; dur = 16'd7; idle(2);
    tr = 1'b1; idle(4);
    c = cyc; tn = 1'b0; push(c + 3, 7, "R2");
    idle(14); tn = 1'b1; idle(4);

    // R3: clear release with both triggers asserted; falls under clear ignored
    dur = 16'd4;
    cn = 1'b0; idle(4);
    tn = 1'b0; idle(4);
    c = cyc; cn = 1'b1; push(c + 3, 4, "R3");
    idle(10);

    // R4: inhibit
    tn = 1'b1; tr = 1'b0; idle(4);
    r0 = rises;
    for (int i = 0; i < 3; i++) begin tr = 1'b1; idle(2); tr = 1'b0; idle(2); end
    for (int i = 0; i < 3; i++) begin tn = 1'b0; idle(2); tn = 1'b1; idle(2); end
    idle(6);
    check(rises == r0, "R4 inhibited edges", rises - r0, 0);

    // R5: events during a long pulse
    dur = 16'd20; tn = 1'b0; idle(3);
    c = cyc; tr = 1'b1; push(c + 3, 20, "R5");
    idle(6);
    tr = 1'b0; idle(2); tr = 1'b1; idle(2); tn = 1'b1; idle(2); tn = 1'b0; idle(2);
    idle(20);

    // R5 boundary: event landing in the final busy cycle is lost
    tr = 1'b0; dur = 16'd6; idle(3);
    c = cyc; tr = 1'b1; push(c + 3, 6, "R5 boundary");
    idle(2); tr = 1'b0; idle(4); tr = 1'b1;
    idle(14);

    // R12: re-arm right after the end
    tr = 1'b0; idle(3);
    c = cyc; tr = 1'b1; push(c + 3, 6, "R12 first");
    idle(3); tr = 1'b0; idle(4); tr = 1'b1; push(c + 10, 6, "R12 second");
    idle(14);

    // R6: clear cuts a pulse, then triggers under clear are ignored
    tr = 1'b0; dur = 16'd30; idle(3);
    c = cyc; tr = 1'b1; push(c + 3, 12, "R6 cut");
    idle(13); cn = 1'b0; idle(5);
    r0 = rises;
    tn = 1'b1; idle(2); tn = 1'b0; idle(2); tn = 1'b1; idle(2);
    cn = 1'b1; idle(8);
    check(rises == r0, "R6 no start under clear", rises - r0, 0);

    // R7: long trigger, then 1-cycle trigger with dur changed after capture
    tn = 1'b0; tr = 1'b0; dur = 16'd6; idle(3);
    c = cyc; tr = 1'b1; push(c + 3, 6, "R7 long trigger");
    idle(40); tr = 1'b0; dur = 16'd9; idle(3);
    c = cyc; tr = 1'b1; push(c + 3, 9, "R7 short trigger/capture");
    idle(1); tr = 1'b0; idle(2); dur = 16'd3;
    idle(15);

    // R9: zero length, then length one
    dur = 16'd0; idle(2);
    r0 = rises;
    tr = 1'b1; idle(10);
    check(rises == r0, "R9 zero duration", rises - r0, 0);
    tr = 1'b0; dur = 16'd1; idle(3);
    c = cyc; tr = 1'b1; push(c + 3, 1, "R9 one cycle");
    idle(10);

    check(q.size() == 0, "R9 all expected pulses seen", q.size(), 0);
    check(compl_bad == 0, "R11 complement", compl_bad, 0);
    done = 1'b1;
    summary();
  end
endmodule